// File: doc/BRIEF.md
# Carry-Less 64-Bit Polynomial Multiplier with Selectable Method

This block forms the full product of two 64-bit polynomials over GF(2). Bits are added with XOR, so no carries arise, and the result is 127 bits wide. The coefficient of x^k sits at bit k of every vector. The block does no field reduction and no operand sequencing. It is the partial-product engine that a wider serial field multiplier calls once per step.

A string parameter chooses how the product is built. The `CLASSICAL` method forms every AND term and XOR-sums them. The `KARATSUBA` method halves the operands four times, down to 4-bit segments. That gives 81 small schoolbook products, which are then recombined with the three-product identity. Both methods have exactly the same ports and give bit-identical results. A design can therefore swap one for the other, or pick one per build, without the surrounding logic noticing. Any other method name stops elaboration.

A second parameter adds an output register clocked by `clk`. With it cleared, the result is purely combinational and the clock is unused.

Top module: `polymul_gf2`

## Requirements
- R1: Bit k of `prod` equals the XOR, over all i, of `op_a[i] & op_b[k-i]`, where 0 <= k <= 126.
- R2: With `METHOD` set to "CLASSICAL" and with it set to "KARATSUBA", the block gives the same `prod` for every operand pair.
- R3: If either operand is zero, `prod` is zero.
- R4: If `op_b` is 1 (the constant polynomial), `prod` equals `op_a` zero-extended to 127 bits. The same holds with the two operands swapped.
- R5: `prod[126]` equals `op_a[63] & op_b[63]`. Squaring the all-ones operand sets every even bit of `prod` and clears every odd bit.
- R6: The XOR of all bits of `prod` equals `(^op_a) & (^op_b)`.
- R7: With `OUT_REG` = 1, `prod` takes the product of the operands seen at a rising edge of `clk`, keeps its value until the next rising edge, and reads zero while `rst_n` is low.
- R8: With `OUT_REG` = 0, `prod` follows the operands with no clock edge in between.
- R9: Swapping `op_a` and `op_b` leaves `prod` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| op_a | input | 64 | First polynomial operand |
| op_b | input | 64 | Second polynomial operand |
| prod | output | 127 | Carry-less product |

## Verification
The bench places both methods side by side, each with and without the output register, and compares all four against a shift-and-XOR model. Seeded random operand pairs exercise the middle and cross terms of every Karatsuba level at once. Random pairs alone could leave a wrong recombination shift unnoticed at the segment edges. Directed operands cover that case: zero, the unit polynomial, a lone top bit, the all-ones square and alternating patterns. These separate a wrong leaf operand or shift from a correct result. Timing checks taken just before and just after an edge tell the registered instances apart from the combinational ones.

// File: rtl/polymul_gf2.sv
module polymul_gf2 #(
  parameter string METHOD  = "KARATSUBA",
  parameter int    W       = 64,
  parameter int    LEAF    = 4,
  parameter bit    OUT_REG = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  output logic [2*W-2:0] prod
);

  localparam int PW   = 2*W-1;
  localparam int SEGS = W / LEAF;
  localparam int LVL  = $clog2(SEGS);

  function automatic int pow3(input int e);
    int r = 1;
    for (int i = 0; i < e; i++) r = r * 3;
    return r;
  endfunction

  function automatic int lvl_base(input int g);
    int r = 0;
    for (int i = 0; i < g; i++) r = r + pow3(LVL - i);
    return r;
  endfunction

  localparam int NLEAF = pow3(LVL);
  localparam int TOT   = lvl_base(LVL) + 1;

  function automatic logic [PW-1:0] clmul(input logic [W-1:0] x, input logic [W-1:0] y, input int n);
    logic [PW-1:0] r = '0;
    for (int i = 0; i < n; i++)
      for (int j = 0; j < n; j++)
        r[i+j] = r[i+j] ^ (x[i] & y[j]);
    return r;
  endfunction

  logic [PW-1:0] full;

  if (METHOD == "CLASSICAL") begin : g_classic
    assign full = clmul(op_a, op_b, W);
  end else if (METHOD == "KARATSUBA") begin : g_kara
    if ((1 << LVL) != SEGS || SEGS * LEAF != W) begin : g_badsz
      $error("polymul_gf2: W/LEAF must be a power of two");
    end

    logic [PW-1:0] leaf [NLEAF];
    logic [PW-1:0] node [TOT];

    always_comb begin
      for (int i = 0; i < NLEAF; i++) begin
        logic [W-1:0] la, lb;
        la = '0;
        lb = '0;
        for (int s = 0; s < SEGS; s++) begin
          logic take;
          int   d, dig;
          take = 1'b1;
          d    = i;
          for (int p = 0; p < LVL; p++) begin
            dig = d % 3;
            d   = d / 3;
            if (dig != 2 && ((s >> p) & 1) != dig) take = 1'b0;
          end
          if (take) begin
            la[LEAF-1:0] = la[LEAF-1:0] ^ op_a[s*LEAF +: LEAF];
            lb[LEAF-1:0] = lb[LEAF-1:0] ^ op_b[s*LEAF +: LEAF];
          end
        end
        leaf[i] = clmul(la, lb, LEAF);
      end
    end

    for (genvar k = 0; k < NLEAF; k++) begin : g_leaf
      assign node[k] = leaf[k];
    end

    for (genvar g = 1; g <= LVL; g++) begin : g_lvl
      localparam int H   = LEAF << (g-1);
      localparam int CNT = pow3(LVL - g);
      localparam int SRC = lvl_base(g-1);
      localparam int DST = lvl_base(g);
      for (genvar k = 0; k < CNT; k++) begin : g_node
        wire [PW-1:0] lo  = node[SRC + 3*k];
        wire [PW-1:0] hi  = node[SRC + 3*k + 1];
        wire [PW-1:0] mid = node[SRC + 3*k + 2];
        assign node[DST + k] = lo ^ (hi << (2*H)) ^ ((lo ^ hi ^ mid) << H);
      end
    end

    assign full = node[TOT-1];
  end else begin : g_badm
    $error("polymul_gf2: METHOD must be CLASSICAL or KARATSUBA");
    assign full = '0;
  end

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) prod <= '0;
      else        prod <= full;

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $stable(op_a) && $stable(op_b)) |=> $stable(prod));
  end else begin : g_comb
    assign prod = full;
  end

  a_r3_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (op_a == '0 || op_b == '0) |-> full == '0);
  a_r4_unit: assert property (@(posedge clk) disable iff (!rst_n)
    (op_b == W'(1)) |-> full == PW'(op_a));
  a_r5_top: assert property (@(posedge clk) disable iff (!rst_n)
    full[PW-1] == (op_a[W-1] & op_b[W-1]));
  a_r6_parity: assert property (@(posedge clk) disable iff (!rst_n)
    (^full) == ((^op_a) & (^op_b)));

endmodule

// File: tb/polymul_gf2_bench.sv
module polymul_gf2_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [63:0] op_a = '0, op_b = '0;
  logic [126:0] p_kr, p_kc, p_cr, p_cc;
  logic [126:0] prev_exp = '0;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  polymul_gf2 #(.METHOD("KARATSUBA"), .OUT_REG(1'b1)) u_polymul_gf2
    (.clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .prod(p_kr));
  polymul_gf2 #(.METHOD("KARATSUBA"), .OUT_REG(1'b0)) u_polymul_gf2_kc
    (.clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .prod(p_kc));
  polymul_gf2 #(.METHOD("CLASSICAL"), .OUT_REG(1'b1)) u_polymul_gf2_cr
    (.clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .prod(p_cr));
  polymul_gf2 #(.METHOD("CLASSICAL"), .OUT_REG(1'b0)) u_polymul_gf2_cc
    (.clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .prod(p_cc));

  function automatic logic [126:0] ref_mul(input logic [63:0] a, input logic [63:0] b);
    logic [126:0] r = '0;
    for (int i = 0; i < 64; i++)
      if (b[i]) r = r ^ (127'(a) << i);
    return r;
  endfunction

  task automatic chk(input string req, input logic [126:0] got, input logic [126:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply(input logic [63:0] a, input logic [63:0] b);
    logic [126:0] e;
    @(negedge clk);
    op_a = a;
    op_b = b;
    e = ref_mul(a, b);
    #1;
    chk("R1/R8 classical comb", p_cc, e);
    chk("R1/R8 karatsuba comb", p_kc, e);
    chk("R2 methods agree", p_kc, p_cc);
    chk("R6 parity", 127'((^p_kc)), 127'((^a) & (^b)));
    chk("R7 karatsuba reg holds before edge", p_kr, prev_exp);
    chk("R7 classical reg holds before edge", p_cr, prev_exp);
    @(posedge clk);
    #1;
    chk("R7 karatsuba reg after edge", p_kr, e);
    chk("R7 classical reg after edge", p_cr, e);
    prev_exp = e;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [126:0] even, sw;
    logic [63:0] ra, rb;
    void'($urandom(32'h5eed_1234));
    op_a = 64'hdead_beef_0123_4567;
    op_b = 64'h0f0f_a5a5_ffff_0001;
    repeat (3) @(posedge clk);
    #1;
    chk("R7 reset karatsuba reg", p_kr, '0);
    chk("R7 reset classical reg", p_cr, '0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    prev_exp = ref_mul(op_a, op_b);

    apply('0, 64'hffff_ffff_ffff_ffff);
    chk("R3 zero operand", p_kc, '0);
    apply(64'h8000_0000_1234_5678, '0);
    chk("R3 zero operand", p_cc, '0);
    apply(64'h0123_4567_89ab_cdef, 64'd1);
    chk("R4 unit b", p_kc, 127'(64'h0123_4567_89ab_cdef));
    apply(64'd1, 64'hfedc_ba98_7654_3210);
    chk("R4 unit a", p_kc, 127'(64'hfedc_ba98_7654_3210));
    apply(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000);
    chk("R5 top bit", 127'(p_kc[126]), 127'(1));
    even = '0;
    for (int i = 0; i < 127; i += 2) even[i] = 1'b1;
    apply('1, '1);
    chk("R5 all-ones square karatsuba", p_kc, even);
    chk("R5 all-ones square classical", p_cc, even);
    apply(64'haaaa_aaaa_aaaa_aaaa, 64'h5555_5555_5555_5555);
    apply(64'h0000_000f_0000_000f, 64'hf000_0000_f000_0000);
    apply(64'h8000_0000_0000_0001, 64'hffff_0000_ffff_0000);

    for (int n = 0; n < 300; n++) begin
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      if (n % 7 == 0) ra = ra & {16{4'h9}};
      apply(ra, rb);
      sw = p_kc;
      apply(rb, ra);
      chk("R9 commutative", p_kc, sw);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule